// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Operand Pre-Scaling and Result Post-Scaling

This block is a fixed-point multiply-accumulate engine for filter, convolution and transform loops. Each operation presents a signed data sample, a signed coefficient and a small shift amount. The data sample is divided by a power of two through an arithmetic right shift before it reaches the multiplier. The coefficient is used as given. The product is added to a wide accumulator. An accumulate-restart input lets a new sum begin with the current product.

A separate output scale register is loaded before a run of operations. Every readout of the accumulator is shifted right by that amount until the register is written again. The accumulator saturates at its extreme values instead of wrapping. Two sticky flags record whether saturation happened at the top or at the bottom, so software can check the health of a whole block of operations and then clear the flags.

Top module: `mac_scaled`

## Requirements
- R1: After reset, `out_valid` is 0, both flags are 0, the accumulator is 0 and the output scale register is 0, so `result` reads 0.
- R2: For an operation, the data operand is arithmetically shifted right by `pre_shift` (0 to 7; for example, 2 divides by 4 with rounding toward minus infinity) before the multiply. The coefficient enters the multiplier unshifted.
- R3: When `in_valid` is 1 and `acc_restart` is 0, the accumulator becomes the old accumulator plus the signed 32-bit product.
- R4: When `in_valid` and `acc_restart` are both 1, the accumulator becomes the current product alone.
- R5: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` 1, and `result` reflects that operation in the same cycle.
- R6: A cycle with `cfg_we` 1 loads `cfg_post` (0 to 15) into the output scale register. `result` equals the accumulator arithmetically shifted right by that register, and the value applies until the next write.
- R7: A sum above 2^39-1 stores 2^39-1 and sets `ovf_flag`.
- R8: A sum below -2^39 stores -2^39 and sets `unf_flag`.
- R9: The flags are sticky and are cleared only by `flag_clr`. A saturation in the same cycle as `flag_clr` leaves its flag set.
- R10: While `in_valid` is 0, the data, coefficient, shift and restart inputs have no effect, and the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| data_in | input | 16 | Signed data operand |
| coef_in | input | 16 | Signed coefficient operand |
| pre_shift | input | 3 | Right shift applied to the data operand |
| acc_restart | input | 1 | Start a new sum with this product |
| cfg_we | input | 1 | Load the output scale register |
| cfg_post | input | 4 | Output scale value (right shift) |
| flag_clr | input | 1 | Clear both sticky flags |
| out_valid | output | 1 | Result of an operation is ready |
| result | output | 40 | Post-scaled signed accumulator |
| ovf_flag | output | 1 | Sticky saturation-high flag |
| unf_flag | output | 1 | Sticky saturation-low flag |

## Verification
The hardest state to reach is saturation, because one product moves the 40-bit accumulator by at most 2^30. The bench drives long runs of full-scale products in both signs, more than 512 operations each, until the accumulator clamps. It then keeps pushing past the limit, including an operation that coincides with a flag clear, and checks that the clamped value and the sticky flags behave as required.

// File: rtl/mac_scaled.sv
module mac_scaled #(
  parameter int DW  = 16,
  parameter int AW  = 40,
  parameter int PSW = 3,
  parameter int QSW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] data_in,
  input  logic signed [DW-1:0] coef_in,
  input  logic [PSW-1:0]       pre_shift,
  input  logic                 acc_restart,
  input  logic                 cfg_we,
  input  logic [QSW-1:0]       cfg_post,
  input  logic                 flag_clr,
  output logic                 out_valid,
  output logic signed [AW-1:0] result,
  output logic                 ovf_flag,
  output logic                 unf_flag
);
  localparam int PW = 2 * DW;
  localparam int SW = AW + 1;
  localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [AW-1:0] acc;
  logic [QSW-1:0]       post_q;
  logic signed [DW-1:0] data_shf;
  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] base, sum;
  logic                 sat_hi, sat_lo;

  assign data_shf = data_in >>> pre_shift;
  assign prod     = PW'(data_shf) * PW'(coef_in);
  assign base     = acc_restart ? '0 : {acc[AW-1], acc};
  assign sum      = base + {{(SW-PW){prod[PW-1]}}, prod};
  assign sat_hi   = !sum[SW-1] &&  sum[SW-2];
  assign sat_lo   =  sum[SW-1] && !sum[SW-2];
  assign result   = acc >>> post_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      post_q    <= '0;
      out_valid <= 1'b0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (cfg_we) post_q <= cfg_post;
      if (in_valid) begin
        if (sat_hi)      acc <= ACC_MAX;
        else if (sat_lo) acc <= ACC_MIN;
        else             acc <= sum[AW-1:0];
      end
      ovf_flag <= (ovf_flag && !flag_clr) || (in_valid && sat_hi);
      unf_flag <= (unf_flag && !flag_clr) || (in_valid && sat_lo);
    end
  end
endmodule

module mac_scaled_chk #(
  parameter int AW = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 cfg_we,
  input logic                 flag_clr,
  input logic                 out_valid,
  input logic signed [AW-1:0] result,
  input logic                 ovf_flag,
  input logic                 unf_flag
);
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !cfg_we |=> $stable(result));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag && !flag_clr |=> unf_flag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !in_valid |=> !ovf_flag && !unf_flag);
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag && !in_valid |=> !ovf_flag);
  assert_unf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !unf_flag && !in_valid |=> !unf_flag);
endmodule

bind mac_scaled mac_scaled_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_we(cfg_we),
  .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/mac_scaled_tb.sv
module mac_scaled_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, acc_restart = 1'b0, cfg_we = 1'b0, flag_clr = 1'b0;
  logic signed [15:0] data_in = '0, coef_in = '0;
  logic [2:0] pre_shift = '0;
  logic [3:0] cfg_post = '0;
  logic out_valid, ovf_flag, unf_flag;
  logic signed [39:0] result;

  int checks = 0, errors = 0;
  longint m_acc = 0;
  int m_post = 0;
  bit m_ovf = 0, m_unf = 0;
  localparam longint AMAX = (64'sd1 <<< 39) - 1;
  localparam longint AMIN = -(64'sd1 <<< 39);

  always #10 clk = ~clk;

  mac_scaled dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
    .coef_in(coef_in), .pre_shift(pre_shift), .acc_restart(acc_restart),
    .cfg_we(cfg_we), .cfg_post(cfg_post), .flag_clr(flag_clr),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, bit vld);
    chk({tag, " result"}, longint'(result), m_acc >>> m_post);
    chk({tag, " out_valid"}, longint'(out_valid), longint'(vld));
    chk({tag, " ovf_flag"}, longint'(ovf_flag), longint'(m_ovf));
    chk({tag, " unf_flag"}, longint'(unf_flag), longint'(m_unf));
  endtask

  task automatic op(int d, int c, int sh, bit rs, bit fc, string tag);
    longint p, s;
    data_in = 16'(d); coef_in = 16'(c); pre_shift = 3'(sh);
    acc_restart = rs; flag_clr = fc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0; acc_restart = 1'b0;
    p = (longint'(d) >>> sh) * longint'(c);
    s = (rs ? 0 : m_acc) + p;
    if (fc) begin m_ovf = 0; m_unf = 0; end
    if (s > AMAX) begin m_acc = AMAX; m_ovf = 1; end
    else if (s < AMIN) begin m_acc = AMIN; m_unf = 1; end
    else m_acc = s;
    chk_all(tag, 1'b1);
  endtask

  task automatic set_post(int q);
    cfg_post = 4'(q); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; m_post = q;
    chk_all("R6 post scale", 1'b0);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; m_ovf = 0; m_unf = 0;
    chk_all("R9 flag clear", 1'b0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dv[6] = '{32767, -32768, 12345, -7, 1, -1};
    int cv[4] = '{32767, -32768, 3, -2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset", 1'b0);

    // R2/R4: sweep every pre-shift with restart, data and coefficient patterns
    foreach (dv[i]) foreach (cv[j]) for (int sh = 0; sh < 8; sh++)
      op(dv[i], cv[j], sh, 1'b1, 1'b0, "R2 R4 prescale");

    // R3: accumulate over mixed shifts
    op(1000, 1000, 0, 1'b1, 1'b0, "R4 restart");
    for (int k = 0; k < 40; k++)
      op(-32768 + k * 1601, 777 - k * 37, k % 8, 1'b0, 1'b0, "R3 accumulate");

    // R10: idle cycles with moving inputs
    for (int k = 0; k < 8; k++) begin
      data_in = 16'(k * 999); coef_in = 16'(-k * 77);
      pre_shift = 3'(k); acc_restart = k[0];
      @(negedge clk);
      chk_all("R10 idle hold", 1'b0);
    end
    acc_restart = 1'b0;

    // R5: back-to-back operations then idle
    op(-5000, 3, 1, 1'b1, 1'b0, "R5 latency");
    op(7, 9, 0, 1'b0, 1'b0, "R5 latency");
    @(negedge clk);
    chk_all("R5 idle", 1'b0);

    // R6: sweep output scale over a large positive and negative value
    op(32767, 32767, 0, 1'b1, 1'b0, "R6 setup");
    for (int q = 0; q < 16; q++) set_post(q);
    op(-32768, 32767, 0, 1'b0, 1'b0, "R6 setup");
    op(-32768, 32767, 0, 1'b0, 1'b0, "R6 setup");
    for (int q = 15; q >= 0; q--) set_post(q);
    op(123, 456, 0, 1'b0, 1'b0, "R6 persists");

    // R7: drive to positive saturation, then clear coinciding with saturation
    op(-32768, -32768, 0, 1'b1, 1'b0, "R7 start");
    for (int k = 0; k < 520; k++)
      op(-32768, -32768, 0, 1'b0, k == 515, "R7 R9 saturate high");
    chk("R7 clamp max", longint'(result), AMAX);
    set_post(4);
    op(-4, 1, 2, 1'b0, 1'b0, "R6 R7 after clamp");
    set_post(0);
    clear_flags();

    // R8: drive to negative saturation
    op(-32768, 32767, 0, 1'b1, 1'b0, "R8 start");
    for (int k = 0; k < 520; k++)
      op(-32768, 32767, 0, 1'b0, k == 517, "R8 R9 saturate low");
    chk("R8 clamp min", longint'(result), AMIN);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_all("R9 sticky idle", 1'b0);
    end
    clear_flags();
    op(5, 5, 0, 1'b1, 1'b0, "R4 R9 after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule